// File: doc/BRIEF.md
# Multiplexed external memory access sequencer

This block carries one asynchronous access at a time from an internal request port out to an external memory or peripheral. A request carries an address, write data, byte enables, a direction bit, a page-read hint and a chip-select index. The sequencer then walks the external pins through the address, strobe, hold and turnaround phases. The length of each phase comes from that chip select's own timing fields. The result returns on a one-cycle completion pulse, and read data rides on that pulse.

Each of the four chip selects has its own settings for pin layout, bus width, phase counts and the handling of the WAIT input. There are three pin layouts. In the separate layout the address goes out on dedicated pins. In the shared layout the address is driven once on the data pins under the address-valid strobe. In the split shared layout two address phases are driven on the data pins: the upper part first, then the lower 16 bits. When nothing drives the data pins, the last driven value stays on them.

Top module: `ext_mem_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the timing fields of the selected chip are captured at that edge.
- R2: The address phase lasts setup+1 cycles with `mem_adv_n` low. The strobe (`mem_oe_n` for a read, `mem_we_n` for a write) is low for access+1 cycles when WAIT is not stalling. The chip select stays low for a further hold+1 cycles. `done` is high for exactly one cycle, in the cycle after the hold phase ends.
- R3: Only the selected chip's `mem_cs_n` bit goes low, and only during the address, strobe and hold phases. Each chip uses its own fields: chip k uses bits [2k+1:2k] of the mode and width fields and bits [4k+3:4k] of the timing fields.
- R4: Mode code 1 is the shared layout. During its address phase `mem_ad_oe` is high and `mem_ad_o` carries the address, zero-extended.
- R5: Mode code 2 is the split shared layout. It has two address phases of setup+1 cycles each: the first drives address bits above bit 15, and the second drives address bits [15:0].
- R6: Mode code 0 (and the spare code 3) is the separate layout. `mem_addr` carries the address, and `mem_ad_oe` stays low during the address phase.
- R7: Width code 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. Byte i of the data sits on bits 8i+7:8i (little-endian). Write data lanes at and above the width are driven as zero, read data above the width returns as zero, and `mem_be_n` is the inverted byte enables with the lanes above the width held high.
- R8: When the chip's WAIT enable is set, the WAIT pin passes through a two-flop synchronizer and is compared with the chip's polarity bit (1 = stall while high). A stall holds the strobe past its last counted cycle. A pin change takes effect two cycles after it is driven. With the enable clear, the pin has no effect.
- R9: After `done`, `req_ready` stays low for exactly `turn` cycles. During these cycles all chip selects are high and `mem_ad_oe` is low.
- R10: A read with `req_page` set to a chip in mode 1 or 2 is rejected. `done` and `done_err` rise in the next cycle and no pin activity takes place. In mode 0 such a read runs as a normal access.
- R11: While `mem_ad_oe` is low, `mem_ad_o` holds the value it was last driven with.
- R12: `mem_oe_n` and `mem_we_n` are never both low, and `mem_ad_oe` is low whenever `mem_oe_n` is low.
- R13: After reset all chip selects, `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high, `done` and `mem_ad_oe` are low, and `req_ready` is high once the reset release has passed through its two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_page | input | 1 | Page-read hint |
| req_cs | input | CSW | Chip-select index |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request rejected (valid with done) |
| rdata | output | 32 | Read data (valid with done) |
| cfg_mode | input | 2*NCS | Pin layout per chip |
| cfg_width | input | 2*NCS | Bus width code per chip |
| cfg_setup | input | 4*NCS | Address phase count per chip |
| cfg_access | input | 4*NCS | Strobe count per chip |
| cfg_hold | input | 4*NCS | Hold count per chip |
| cfg_turn | input | 4*NCS | Turnaround count per chip |
| cfg_wait_en | input | NCS | WAIT handshake enable per chip |
| cfg_wait_pol | input | NCS | WAIT stall level per chip |
| mem_cs_n | output | NCS | Chip selects, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 4 | Byte enables, active low |
| mem_addr | output | ADDR_W | Separate address pins |
| mem_ad_o | output | 32 | Shared address/data pins, outgoing value |
| mem_ad_oe | output | 1 | Drive enable for mem_ad_o |
| mem_ad_i | input | 32 | Shared address/data pins, incoming value |
| mem_wait | input | 1 | External WAIT pin |

## Verification
Completion and acceptance can fall in the same cycle. With a turnaround count of zero, the cycle that shows `done` also shows `req_ready`, so a request held high is taken on the very next edge. The bench keeps `req_valid` asserted across the first completion and judges the outcome at the pins: the second chip-select and address-valid must go low one cycle after the pulse. The bench also lines up WAIT release against the last counted strobe cycle and expects the strobe to stay low for exactly two more cycles.

// File: rtl/emseq_pkg.sv
package emseq_pkg;

  localparam int TIME_W = 4;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    PM_SEPARATE = 2'd0,
    PM_AD       = 2'd1,
    PM_AAD      = 2'd2,
    PM_SPARE    = 2'd3
  } pin_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_HI,
    ST_ADDR,
    ST_ACCESS,
    ST_HOLD,
    ST_TURN
  } seq_state_e;

  typedef struct packed {
    pin_mode_e         mode;
    logic [1:0]        width;
    logic [TIME_W-1:0] setup;
    logic [TIME_W-1:0] access;
    logic [TIME_W-1:0] hold;
    logic [TIME_W-1:0] turn;
    logic              wait_en;
    logic              wait_pol;
  } cs_timing_t;

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] wcode);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) begin
      m[i] = (i == 0) || (i == 1 && wcode != 2'd0) || (wcode[1]);
    end
    return m;
  endfunction

  function automatic logic [8*LANES-1:0] data_mask(input logic [1:0] wcode);
    logic [LANES-1:0]   lm;
    logic [8*LANES-1:0] dm;
    lm = lane_mask(wcode);
    for (int i = 0; i < LANES; i++) begin
      dm[8*i +: 8] = {8{lm[i]}};
    end
    return dm;
  endfunction

endpackage

// File: rtl/emseq_cfg_sel.sv
module emseq_cfg_sel
  import emseq_pkg::*;
#(
  parameter int NCS = 4,
  parameter int CSW = 2
)(
  input  logic [2*NCS-1:0]      cfg_mode,
  input  logic [2*NCS-1:0]      cfg_width,
  input  logic [TIME_W*NCS-1:0] cfg_setup,
  input  logic [TIME_W*NCS-1:0] cfg_access,
  input  logic [TIME_W*NCS-1:0] cfg_hold,
  input  logic [TIME_W*NCS-1:0] cfg_turn,
  input  logic [NCS-1:0]        cfg_wait_en,
  input  logic [NCS-1:0]        cfg_wait_pol,
  input  logic [CSW-1:0]        sel,
  output cs_timing_t            cfg
);

  cs_timing_t per_cs [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign per_cs[g] = '{
      mode:     pin_mode_e'(cfg_mode[2*g +: 2]),
      width:    cfg_width[2*g +: 2],
      setup:    cfg_setup[TIME_W*g +: TIME_W],
      access:   cfg_access[TIME_W*g +: TIME_W],
      hold:     cfg_hold[TIME_W*g +: TIME_W],
      turn:     cfg_turn[TIME_W*g +: TIME_W],
      wait_en:  cfg_wait_en[g],
      wait_pol: cfg_wait_pol[g]
    };
  end

  assign cfg = per_cs[sel];

endmodule

// File: rtl/emseq_wait_sync.sv
module emseq_wait_sync (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin,
  output logic synced
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
    end
  end

  assign synced = sync_q;

endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import emseq_pkg::*;
#(
  parameter  int NCS    = 4,
  parameter  int ADDR_W = 26,
  localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int DW     = 8 * LANES
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic                  req_page,
  input  logic [CSW-1:0]        req_cs,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DW-1:0]         req_wdata,
  input  logic [LANES-1:0]      req_be,
  output logic                  done,
  output logic                  done_err,
  output logic [DW-1:0]         rdata,
  input  logic [2*NCS-1:0]      cfg_mode,
  input  logic [2*NCS-1:0]      cfg_width,
  input  logic [TIME_W*NCS-1:0] cfg_setup,
  input  logic [TIME_W*NCS-1:0] cfg_access,
  input  logic [TIME_W*NCS-1:0] cfg_hold,
  input  logic [TIME_W*NCS-1:0] cfg_turn,
  input  logic [NCS-1:0]        cfg_wait_en,
  input  logic [NCS-1:0]        cfg_wait_pol,
  output logic [NCS-1:0]        mem_cs_n,
  output logic                  mem_adv_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [LANES-1:0]      mem_be_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DW-1:0]         mem_ad_o,
  output logic                  mem_ad_oe,
  input  logic [DW-1:0]         mem_ad_i,
  input  logic                  mem_wait
);

  localparam int LOW_W = 16;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  cs_timing_t sel_cfg;
  logic       wait_s;

  emseq_cfg_sel #(.NCS(NCS), .CSW(CSW)) cfg_sel_i (
    .cfg_mode     (cfg_mode),
    .cfg_width    (cfg_width),
    .cfg_setup    (cfg_setup),
    .cfg_access   (cfg_access),
    .cfg_hold     (cfg_hold),
    .cfg_turn     (cfg_turn),
    .cfg_wait_en  (cfg_wait_en),
    .cfg_wait_pol (cfg_wait_pol),
    .sel          (req_cs),
    .cfg          (sel_cfg)
  );

  emseq_wait_sync wait_sync_i (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pin    (mem_wait),
    .synced (wait_s)
  );

  seq_state_e        state_q, state_d;
  logic [TIME_W-1:0] cnt_q, cnt_d;
  cs_timing_t        cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q, rdata_q, rdata_d, keep_q, ad_drive;
  logic [LANES-1:0]  be_q;
  logic [CSW-1:0]    cs_q;
  logic              we_q, done_q, done_d, err_q, err_d, rdata_en;
  logic              accept, reject, stall, active, muxed, addr_phase;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign reject = !req_we && req_page && (sel_cfg.mode inside {PM_AD, PM_AAD});
  assign stall  = cfg_q.wait_en && (wait_s == cfg_q.wait_pol);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    rdata_en = 1'b0;
    rdata_d  = mem_ad_i & data_mask(cfg_q.width);
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (reject) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            state_d = (sel_cfg.mode == PM_AAD) ? ST_ADDR_HI : ST_ADDR;
            cnt_d   = sel_cfg.setup;
          end
        end
      end
      ST_ADDR_HI: begin
        if (cnt_q == '0) begin
          state_d = ST_ADDR;
          cnt_d   = cfg_q.setup;
        end else cnt_d = cnt_q - TIME_W'(1);
      end
      ST_ADDR: begin
        if (cnt_q == '0) begin
          state_d = ST_ACCESS;
          cnt_d   = cfg_q.access;
        end else cnt_d = cnt_q - TIME_W'(1);
      end
      ST_ACCESS: begin
        if (cnt_q != '0) cnt_d = cnt_q - TIME_W'(1);
        else if (!stall) begin
          rdata_en = !we_q;
          state_d  = ST_HOLD;
          cnt_d    = cfg_q.hold;
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          done_d = 1'b1;
          if (cfg_q.turn == '0) state_d = ST_IDLE;
          else begin
            state_d = ST_TURN;
            cnt_d   = cfg_q.turn - TIME_W'(1);
          end
        end else cnt_d = cnt_q - TIME_W'(1);
      end
      ST_TURN: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else cnt_d = cnt_q - TIME_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      cfg_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      cs_q    <= '0;
      we_q    <= 1'b0;
      keep_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (rdata_en) rdata_q <= rdata_d;
      if (accept) begin
        cfg_q   <= sel_cfg;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        cs_q    <= req_cs;
        we_q    <= req_we;
      end
      if (mem_ad_oe) keep_q <= ad_drive;
    end
  end

  // pin decode
  assign active     = state_q inside {ST_ADDR_HI, ST_ADDR, ST_ACCESS, ST_HOLD};
  assign addr_phase = state_q inside {ST_ADDR_HI, ST_ADDR};
  assign muxed      = cfg_q.mode inside {PM_AD, PM_AAD};

  always_comb begin
    ad_drive = wdata_q & data_mask(cfg_q.width);
    if (state_q == ST_ADDR_HI) ad_drive = DW'(addr_q >> LOW_W);
    else if (state_q == ST_ADDR && muxed)
      ad_drive = (cfg_q.mode == PM_AAD) ? DW'(addr_q[LOW_W-1:0]) : DW'(addr_q);
  end

  for (genvar g = 0; g < NCS; g++) begin : g_csn
    assign mem_cs_n[g] = !(active && (cs_q == CSW'(g)));
  end

  assign mem_ad_oe = (muxed && addr_phase) ||
                     (we_q && (state_q inside {ST_ACCESS, ST_HOLD}));
  assign mem_ad_o  = mem_ad_oe ? ad_drive : keep_q;
  assign mem_adv_n = !addr_phase;
  assign mem_oe_n  = !(state_q == ST_ACCESS && !we_q);
  assign mem_we_n  = !(state_q == ST_ACCESS && we_q);
  assign mem_be_n  = active ? ~(be_q & lane_mask(cfg_q.width)) : '1;
  assign mem_addr  = addr_q;

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign done_err  = err_q;
  assign rdata     = rdata_q;

endmodule

// File: rtl/emseq_chk.sv
module emseq_chk #(
  parameter  int NCS = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
)(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_we,
  input logic             req_page,
  input logic [CSW-1:0]   req_cs,
  input logic [2*NCS-1:0] cfg_mode,
  input logic             done,
  input logic             done_err,
  input logic [NCS-1:0]   mem_cs_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic             mem_ad_oe,
  input logic [31:0]      mem_ad_o
);

  logic [1:0] req_mode;
  assign req_mode = cfg_mode[2*req_cs +: 2];

  a_r3_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r12_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ad_oe);

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1) |-> !req_ready);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_page_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_page && !req_we &&
     (req_mode == 2'd1 || req_mode == 2'd2))
    |=> (done && done_err && mem_cs_n == '1));

  a_r11_bus_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ad_oe |-> $stable(mem_ad_o));

  a_r9_turn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_ready) |-> (mem_cs_n == '1 && !mem_ad_oe));

endmodule

bind ext_mem_seq emseq_chk #(.NCS(NCS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_page  (req_page),
  .req_cs    (req_cs),
  .cfg_mode  (cfg_mode),
  .done      (done),
  .done_err  (done_err),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ad_oe (mem_ad_oe),
  .mem_ad_o  (mem_ad_o)
);

// File: tb/ext_mem_seq_tb_top.sv
`timescale 1ns/1ps
module ext_mem_seq_tb_top;

  localparam logic [31:0] PAT = 32'hA5C3_9E71;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_we, req_page;
  logic [1:0]  req_cs;
  logic [25:0] req_addr;
  logic [31:0] req_wdata, rdata;
  logic [3:0]  req_be;
  logic        done, done_err;
  logic [7:0]  cfg_mode, cfg_width;
  logic [15:0] cfg_setup, cfg_access, cfg_hold, cfg_turn;
  logic [3:0]  cfg_wait_en, cfg_wait_pol;
  logic [3:0]  mem_cs_n, mem_be_n;
  logic        mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe, mem_wait;
  logic [25:0] mem_addr;
  logic [31:0] mem_ad_o, mem_ad_i;

  ext_mem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_page(req_page), .req_cs(req_cs), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .done(done), .done_err(done_err),
    .rdata(rdata), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .cfg_setup(cfg_setup), .cfg_access(cfg_access), .cfg_hold(cfg_hold),
    .cfg_turn(cfg_turn), .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_ad_o(mem_ad_o), .mem_ad_oe(mem_ad_oe), .mem_ad_i(mem_ad_i),
    .mem_wait(mem_wait)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]  cs;
    logic [1:0]  mode;
    logic [1:0]  width;
    logic [3:0]  s;
    logic [3:0]  a;
    logic [3:0]  h;
    logic [3:0]  t;
    logic        we;
    logic [25:0] addr;
    logic [31:0] wd;
    logic [3:0]  be;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd2, 4'd1, 4'd2, 4'd1, 4'd2, 1'b0, 26'h0123456, 32'h0,        4'hF},
    '{2'd1, 2'd1, 2'd1, 4'd0, 4'd3, 4'd0, 4'd0, 1'b1, 26'h02ABCDE, 32'h12345678, 4'hF},
    '{2'd2, 2'd2, 2'd0, 4'd2, 4'd0, 4'd2, 4'd1, 1'b0, 26'h3FEDCBA, 32'h0,        4'h1},
    '{2'd3, 2'd0, 2'd1, 4'd3, 4'd1, 4'd0, 4'd3, 1'b1, 26'h0000010, 32'hCAFEBEEF, 4'h2},
    '{2'd2, 2'd2, 2'd2, 4'd0, 4'd0, 4'd0, 4'd0, 1'b1, 26'h1234567, 32'h89ABCDEF, 4'hC},
    '{2'd1, 2'd1, 2'd0, 4'd1, 4'd1, 4'd1, 4'd1, 1'b0, 26'h0000ABC, 32'h0,        4'hF}
  };

  // measurements of the last access
  int          m_lat, m_adv, m_strobe, m_turn;
  logic [31:0] m_ad1, m_ad2, m_wr, m_rd, last_drv;
  logic [25:0] m_addr;
  logic [3:0]  m_ben, m_csn;
  logic        m_err, m_ready_at_done, m_adv_oe, m_bad_turn;

  task automatic set_cfg(input logic [1:0] cs, input logic [1:0] mode, input logic [1:0] w,
                         input logic [3:0] s, input logic [3:0] a, input logic [3:0] h,
                         input logic [3:0] t, input logic wen, input logic wpol);
    cfg_mode[2*cs +: 2]   = mode;
    cfg_width[2*cs +: 2]  = w;
    cfg_setup[4*cs +: 4]  = s;
    cfg_access[4*cs +: 4] = a;
    cfg_hold[4*cs +: 4]   = h;
    cfg_turn[4*cs +: 4]   = t;
    cfg_wait_en[cs]       = wen;
    cfg_wait_pol[cs]      = wpol;
  endtask

  task automatic wait_done_mon();
    m_lat = 1; m_adv = 0; m_strobe = 0; m_adv_oe = 0;
    while (!done && m_lat < 300) begin
      if (!mem_adv_n) begin
        if (m_adv == 0) m_ad1 = mem_ad_o;
        m_ad2 = mem_ad_o;
        m_addr = mem_addr;
        m_adv_oe = m_adv_oe | mem_ad_oe;
        m_adv++;
      end
      if (!mem_oe_n || !mem_we_n) begin
        if (m_strobe == 0) begin
          m_ben = mem_be_n;
          m_wr  = mem_ad_o;
          m_csn = mem_cs_n;
        end
        m_strobe++;
      end
      if (mem_ad_oe) last_drv = mem_ad_o;
      @(posedge clk); @(negedge clk);
      m_lat++;
    end
    m_rd = rdata;
    m_err = done_err;
    m_ready_at_done = req_ready;
    m_turn = 0;
    m_bad_turn = 0;
    while (!req_ready && m_turn < 100) begin
      if (mem_ad_oe || mem_cs_n != 4'hF) m_bad_turn = 1;
      @(posedge clk); @(negedge clk);
      m_turn++;
    end
  endtask

  task automatic do_access(input logic [1:0] cs, input logic we, input logic page,
                           input logic [25:0] a, input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_cs = cs; req_we = we; req_page = page;
    req_addr = a; req_wdata = wd; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done_mon();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_page = 1'b0;
    req_cs = '0; req_addr = '0; req_wdata = '0; req_be = '0;
    cfg_mode = '0; cfg_width = '0; cfg_setup = 16'h7777; cfg_access = 16'h7777;
    cfg_hold = 16'h7777; cfg_turn = 16'h7777; cfg_wait_en = '0; cfg_wait_pol = '0;
    mem_wait = 1'b0; mem_ad_i = PAT; last_drv = '0;

    repeat (3) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_adv_n && mem_oe_n && mem_we_n, "R13 pins in reset",
        {28'd0, mem_cs_n}, 32'hF);
    chk(!done && !mem_ad_oe, "R13 done/oe in reset", {30'd0, done, mem_ad_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R13 ready after release", {31'd0, req_ready}, 32'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic aad, muxed;
      logic [3:0] lm;
      logic [31:0] dm;
      int exp_lat;
      v = VECS[i];
      aad = (v.mode == 2'd2);
      muxed = (v.mode == 2'd1) || (v.mode == 2'd2);
      lm = (v.width == 2'd0) ? 4'h1 : (v.width == 2'd1) ? 4'h3 : 4'hF;
      dm = {{8{lm[3]}}, {8{lm[2]}}, {8{lm[1]}}, {8{lm[0]}}};
      exp_lat = (aad ? int'(v.s) + 1 : 0) + int'(v.s) + int'(v.a) + int'(v.h) + 4;
      set_cfg(v.cs, v.mode, v.width, v.s, v.a, v.h, v.t, 1'b0, 1'b0);
      do_access(v.cs, v.we, 1'b0, v.addr, v.wd, v.be);
      chk(m_lat == exp_lat, "R2 latency to done", m_lat, exp_lat);
      chk(m_strobe == int'(v.a) + 1, "R2 strobe cycles", m_strobe, int'(v.a) + 1);
      chk(m_adv == (int'(v.s) + 1) * (aad ? 2 : 1), "R2 address cycles", m_adv,
          (int'(v.s) + 1) * (aad ? 2 : 1));
      chk(m_csn == ~(4'h1 << v.cs), "R3 selected chip only", {28'd0, m_csn}, {28'd0, ~(4'h1 << v.cs)});
      chk(m_adv_oe == muxed, "R6 R4 address drive enable", {31'd0, m_adv_oe}, {31'd0, muxed});
      if (aad) begin
        chk(m_ad1 == 32'(v.addr >> 16), "R5 upper address phase", m_ad1, 32'(v.addr >> 16));
        chk(m_ad2 == {16'd0, v.addr[15:0]}, "R5 lower address phase", m_ad2, {16'd0, v.addr[15:0]});
      end else if (muxed) begin
        chk(m_ad1 == 32'(v.addr), "R4 shared address", m_ad1, 32'(v.addr));
      end else begin
        chk(m_addr == v.addr, "R6 separate address", 32'(m_addr), 32'(v.addr));
      end
      chk(m_ben == ~(v.be & lm), "R7 byte enables", {28'd0, m_ben}, {28'd0, ~(v.be & lm)});
      if (v.we) chk(m_wr == (v.wd & dm), "R7 write lanes", m_wr, v.wd & dm);
      else      chk(m_rd == (PAT & dm), "R7 read lanes", m_rd, PAT & dm);
      chk(m_err == 1'b0, "R10 no error on plain access", {31'd0, m_err}, 32'd0);
      chk(m_turn == int'(v.t) && !m_bad_turn, "R9 turnaround", m_turn, int'(v.t));
      chk(!mem_ad_oe && mem_ad_o == last_drv, "R11 bus keeping", mem_ad_o, last_drv);
    end

    // page read rejected in shared layout
    set_cfg(2'd1, 2'd1, 2'd2, 4'd1, 4'd1, 4'd1, 4'd0, 1'b0, 1'b0);
    do_access(2'd1, 1'b0, 1'b1, 26'h0000123, 32'h0, 4'hF);
    chk(m_lat == 1 && m_err, "R10 page reject pulse", m_lat, 1);
    chk(m_adv == 0 && m_strobe == 0, "R10 no pin activity", m_adv + m_strobe, 0);

    // page read served in separate layout
    set_cfg(2'd0, 2'd0, 2'd2, 4'd0, 4'd1, 4'd0, 4'd0, 1'b0, 1'b0);
    do_access(2'd0, 1'b0, 1'b1, 26'h0000040, 32'h0, 4'hF);
    chk(!m_err && m_strobe == 2 && m_rd == PAT, "R10 page read separate", m_rd, PAT);

    // WAIT active high, enabled
    set_cfg(2'd1, 2'd0, 2'd2, 4'd0, 4'd1, 4'd0, 4'd0, 1'b1, 1'b1);
    mem_wait = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_cs = 2'd1; req_we = 1'b0; req_page = 1'b0; req_addr = 26'h10;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(!mem_oe_n, "R8 stall while wait high", {31'd0, mem_oe_n}, 32'd0);
    mem_wait = 1'b0;
    begin
      int n;
      n = 0;
      forever begin
        @(posedge clk); @(negedge clk);
        if (mem_oe_n || n > 50) break;
        n++;
      end
      chk(n == 2, "R8 release latency", n, 2);
    end
    wait_done_mon();
    chk(m_rd == PAT, "R8 read after stall", m_rd, PAT);

    // WAIT active low
    set_cfg(2'd2, 2'd0, 2'd2, 4'd0, 4'd1, 4'd0, 4'd0, 1'b1, 1'b0);
    mem_wait = 1'b0;
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_cs = 2'd2; req_we = 1'b1; req_wdata = 32'h0F0F0F0F;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(!mem_we_n, "R8 stall while wait low", {31'd0, mem_we_n}, 32'd0);
    mem_wait = 1'b1;
    begin
      int n;
      n = 0;
      forever begin
        @(posedge clk); @(negedge clk);
        if (mem_we_n || n > 50) break;
        n++;
      end
      chk(n == 2, "R8 release latency low polarity", n, 2);
    end
    wait_done_mon();

    // WAIT ignored when disabled
    set_cfg(2'd3, 2'd0, 2'd2, 4'd0, 4'd1, 4'd0, 4'd0, 1'b0, 1'b1);
    mem_wait = 1'b1;
    repeat (4) @(negedge clk);
    do_access(2'd3, 1'b0, 1'b0, 26'h20, 32'h0, 4'hF);
    chk(m_strobe == 2, "R8 wait disabled no stall", m_strobe, 2);
    mem_wait = 1'b0;

    // completion and acceptance in the same cycle
    set_cfg(2'd0, 2'd0, 2'd2, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_cs = 2'd0; req_we = 1'b0; req_page = 1'b0; req_addr = 26'h30;
    @(posedge clk); @(negedge clk);
    begin
      int n;
      n = 0;
      while (!done && n < 50) begin @(posedge clk); @(negedge clk); n++; end
    end
    chk(req_ready == 1'b1, "R1 ready with done", {31'd0, req_ready}, 32'd1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(mem_cs_n == 4'hE && !mem_adv_n && !done, "R1 back-to-back accept",
        {28'd0, mem_cs_n}, 32'hE);
    wait_done_mon();
    chk(m_rd == PAT, "R2 second access data", m_rd, PAT);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule